// File: doc/BRIEF.md
# Lock-Acquisition Sweep Controller

This block watches a lock indicator for a feedback loop and, when lock is lost, searches for it again. The indicator is either a signed sample tested against a programmable inclusive window or one selected line of a small digital input bus. While the indicator reports lock, the block contributes nothing: its sweep output is zero and the loop filter runs.

When the indicator drops, the block raises a hold line so the loop filter freezes both its output and its internal state. It then drives a triangle sweep around the value its output had at that moment. The sweep moves by a fixed step each clock, so its slew rate is constant. Each time a full swing completes, the amplitude doubles, up to a programmable cap. When the indicator returns, hold is released and the sweep output walks back to zero at the same step rate, landing exactly on zero. If lock drops again during that walk, a new search starts around the present output. The sweep output is meant to be added to the loop-filter output elsewhere.

Top module: `relock_sweeper`

## Requirements
- R1: While in the locked state, `sweep_out` is 0, `hold` is 0 and `locked` is 1. Reset enters the locked state with `sweep_out` = 0.
- R2: If the indicator is false in the locked state, `hold` is 1 from the next clock edge until the indicator is seen true in search.
- R3: In search, each clock `sweep_out` moves by `step` toward the current turning point. A turning point is centre + amplitude going up and centre − amplitude going down, each clamped to the signed output range. When a step would reach or pass the turning point, the output lands exactly on it and the direction reverses. The first move after a loss is upward.
- R4: A search starts with amplitude `amp_init`, and its centre is the value of `sweep_out` when the indicator was seen false. The amplitude changes only when the lower turning point is reached, and then it doubles.
- R5: A doubled amplitude above `amp_max` is replaced by `amp_max`, so the swing stops growing at that value.
- R6: When the indicator is seen true during search, `hold` drops at the next edge. From then on `sweep_out` moves toward zero by `step` per clock, stops exactly at zero without crossing it, and the block then enters the locked state.
- R7: `locked` is 0 exactly while searching and 1 while locked or ramping back to zero. `hold` is its complement.
- R8: With `use_digital` = 1 the indicator is `din[din_sel]` and `sample` is ignored. With `use_digital` = 0 the indicator is true when `lo_bound` <= `sample` <= `hi_bound`, compared as signed values and with both bounds inclusive.
- R9: If the indicator is false during the ramp back to zero, a new search starts at the next edge, centred on the present `sweep_out` and with amplitude `amp_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_digital | input | 1 | 1: indicator from `din`; 0: window test on `sample` |
| din | input | NUM_DIN | Digital lock-indicator lines |
| din_sel | input | $clog2(NUM_DIN) | Index of the line used as indicator |
| sample | input | DATA_W | Signed monitored sample |
| lo_bound | input | DATA_W | Signed lower window bound (inclusive) |
| hi_bound | input | DATA_W | Signed upper window bound (inclusive) |
| step | input | SWEEP_W | Unsigned change of the output per clock, used in search and ramp |
| amp_init | input | SWEEP_W | Unsigned starting amplitude of a search |
| amp_max | input | SWEEP_W | Unsigned cap on the amplitude |
| sweep_out | output | SWEEP_W | Signed sweep contribution |
| hold | output | 1 | Freeze request to the loop filter |
| locked | output | 1 | Lock status |

## Verification
Some properties are checked by assertions on every cycle. The output never changes by more than the step in one clock. It is zero whenever the block is locked. During the ramp it never crosses zero. Hold rises after a loss and falls after a return. The amplitude changes only at the lower turning point and never exceeds the cap after growing. Other behaviour is shown only by the bench's scenarios against its reference model. These are the exact turning-point values, the doubling sequence, the saturated swing, the inclusive window edges, the digital-line selection and the new centre after a loss during the ramp.

// File: rtl/relock_pkg.sv
package relock_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_SEARCH = 2'd1,
    ST_RAMP   = 2'd2
  } relock_state_e;

endpackage

// File: rtl/relock_detect.sv
module relock_detect #(
  parameter int DATA_W  = 24,
  parameter int NUM_DIN = 4
) (
  input  logic                       use_digital,
  input  logic [NUM_DIN-1:0]         din,
  input  logic [$clog2(NUM_DIN)-1:0] din_sel,
  input  logic signed [DATA_W-1:0]   sample,
  input  logic signed [DATA_W-1:0]   lo_bound,
  input  logic signed [DATA_W-1:0]   hi_bound,
  output logic                       lock_ind
);

  logic in_window;
  logic line_sel;

  // R8: inclusive signed window, or one selected digital line
  always_comb begin
    in_window = (sample >= lo_bound) && (sample <= hi_bound);
    line_sel  = din[din_sel];
    lock_ind  = use_digital ? line_sel : in_window;
  end

endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
  import relock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_ind,
  input  logic          at_zero,
  output relock_state_e state,
  output logic          start_search,
  output logic          hold,
  output logic          locked
);

  relock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_LOCKED: if (!lock_ind) state_d = ST_SEARCH;
      ST_SEARCH: if (lock_ind)  state_d = ST_RAMP;
      ST_RAMP: begin
        if (!lock_ind)    state_d = ST_SEARCH;
        else if (at_zero) state_d = ST_LOCKED;
      end
      default: state_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign state        = state_q;
  assign start_search = (state_q != ST_SEARCH) && !lock_ind;
  assign hold         = (state_q == ST_SEARCH);
  assign locked       = (state_q != ST_SEARCH);

  // R2: a loss seen while locked freezes the loop filter at the next edge
  a_r2_hold_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && !lock_ind) |=> (hold && !locked));

  // R6: a return seen during search releases the filter at the next edge
  a_r6_release_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEARCH && lock_ind) |=> (!hold && locked));

  // R9: a loss during the ramp restarts the search
  a_r9_reenter_search: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAMP && !lock_ind) |=> hold);

endmodule

// File: rtl/relock_sweep.sv
module relock_sweep
  import relock_pkg::*;
#(
  parameter int SWEEP_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  relock_state_e             state,
  input  logic                      lock_ind,
  input  logic                      start_search,
  input  logic [SWEEP_W-1:0]        step,
  input  logic [SWEEP_W-1:0]        amp_init,
  input  logic [SWEEP_W-1:0]        amp_max,
  output logic signed [SWEEP_W-1:0] sweep_out,
  output logic                      at_zero
);

  localparam int EXT = SWEEP_W + 2;
  localparam logic signed [EXT-1:0] S_MAX = EXT'((64'sd1 <<< (SWEEP_W - 1)) - 64'sd1);
  localparam logic signed [EXT-1:0] S_MIN = -S_MAX - EXT'(1);

  // clamp a widened value into the signed output range
  function automatic logic signed [EXT-1:0] sat(input logic signed [EXT-1:0] v);
    if (v > S_MAX)      return S_MAX;
    else if (v < S_MIN) return S_MIN;
    else                return v;
  endfunction

  // double an amplitude, capped at lim
  function automatic logic [SWEEP_W-1:0] grow(input logic [SWEEP_W-1:0] a,
                                              input logic [SWEEP_W-1:0] lim);
    logic [SWEEP_W:0] d;
    d = {a, 1'b0};
    if (d > {1'b0, lim}) return lim;
    else                 return d[SWEEP_W-1:0];
  endfunction

  // move v toward zero by s without crossing it
  function automatic logic signed [EXT-1:0] toward_zero(input logic signed [EXT-1:0] v,
                                                        input logic signed [EXT-1:0] s);
    logic signed [EXT-1:0] t;
    if (v > 0) begin
      t = v - s;
      return (t < 0) ? '0 : t;
    end else if (v < 0) begin
      t = v + s;
      return (t > 0) ? '0 : t;
    end else begin
      return '0;
    end
  endfunction

  logic signed [SWEEP_W-1:0] out_q, ctr_q;
  logic        [SWEEP_W-1:0] amp_q;
  logic                      up_q;

  logic signed [EXT-1:0] out_x, ctr_x, step_x, amp_x;
  logic signed [EXT-1:0] peak, trough, rise, fall, home;
  logic                  peak_hit, trough_hit, do_search, do_ramp;

  always_comb begin
    out_x      = EXT'(out_q);
    ctr_x      = EXT'(ctr_q);
    step_x     = EXT'(step);
    amp_x      = EXT'(amp_q);
    peak       = sat(ctr_x + amp_x);
    trough     = sat(ctr_x - amp_x);
    rise       = out_x + step_x;
    fall       = out_x - step_x;
    home       = toward_zero(out_x, step_x);
    peak_hit   = up_q && (rise >= peak);
    trough_hit = !up_q && (fall <= trough);
    do_search  = (state == ST_SEARCH) && !lock_ind;
    do_ramp    = (state == ST_RAMP) && lock_ind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      ctr_q <= '0;
      amp_q <= '0;
      up_q  <= 1'b1;
    end else if (start_search) begin
      ctr_q <= out_q;
      amp_q <= amp_init;
      up_q  <= 1'b1;
    end else if (do_search) begin
      if (up_q) begin
        if (peak_hit) begin
          out_q <= peak[SWEEP_W-1:0];
          up_q  <= 1'b0;
        end else begin
          out_q <= rise[SWEEP_W-1:0];
        end
      end else begin
        if (trough_hit) begin
          out_q <= trough[SWEEP_W-1:0];
          up_q  <= 1'b1;
          amp_q <= grow(amp_q, amp_max);
        end else begin
          out_q <= fall[SWEEP_W-1:0];
        end
      end
    end else if (do_ramp) begin
      out_q <= home[SWEEP_W-1:0];
    end
  end

  assign sweep_out = out_q;
  assign at_zero   = (out_q == '0);

  // R1: no contribution while locked
  a_r1_zero_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKED) |-> (out_q == '0));

  // R3: the output never moves by more than one step per clock
  a_r3_slew_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (((out_x >= $past(out_x)) ? (out_x - $past(out_x)) : ($past(out_x) - out_x))
      <= $past(step_x)));

  // R4: in search the amplitude only changes at the lower turning point
  a_r4_amp_changes_at_trough: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && !start_search && !(do_search && trough_hit)) |=> $stable(amp_q));

  // R5: growth never exceeds the cap
  a_r5_amp_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (do_search && trough_hit && !start_search) |=> (amp_q <= $past(amp_max)));

  // R6: the ramp never crosses zero
  a_r6_ramp_pos_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ramp && !start_search && out_q > 0) |=> (out_q >= 0));
  a_r6_ramp_neg_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ramp && !start_search && out_q < 0) |=> (out_q <= 0));

endmodule

// File: rtl/relock_sweeper.sv
module relock_sweeper
  import relock_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SWEEP_W = 24,
  parameter int NUM_DIN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       use_digital,
  input  logic [NUM_DIN-1:0]         din,
  input  logic [$clog2(NUM_DIN)-1:0] din_sel,
  input  logic signed [DATA_W-1:0]   sample,
  input  logic signed [DATA_W-1:0]   lo_bound,
  input  logic signed [DATA_W-1:0]   hi_bound,
  input  logic [SWEEP_W-1:0]         step,
  input  logic [SWEEP_W-1:0]         amp_init,
  input  logic [SWEEP_W-1:0]         amp_max,
  output logic signed [SWEEP_W-1:0]  sweep_out,
  output logic                       hold,
  output logic                       locked
);

  logic          lock_ind;
  logic          at_zero;
  logic          start_search;
  relock_state_e state;

  relock_detect #(.DATA_W(DATA_W), .NUM_DIN(NUM_DIN)) u_detect (
    .use_digital (use_digital),
    .din         (din),
    .din_sel     (din_sel),
    .sample      (sample),
    .lo_bound    (lo_bound),
    .hi_bound    (hi_bound),
    .lock_ind    (lock_ind)
  );

  relock_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_ind     (lock_ind),
    .at_zero      (at_zero),
    .state        (state),
    .start_search (start_search),
    .hold         (hold),
    .locked       (locked)
  );

  relock_sweep #(.SWEEP_W(SWEEP_W)) u_sweep (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .lock_ind     (lock_ind),
    .start_search (start_search),
    .step         (step),
    .amp_init     (amp_init),
    .amp_max      (amp_max),
    .sweep_out    (sweep_out),
    .at_zero      (at_zero)
  );

  // R7: hold and lock status always reported together, never both
  a_r7_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != locked));

endmodule

// File: tb/relock_sweeper_tb.sv
module relock_sweeper_tb;

  localparam int DW = 24;
  localparam int SW = 24;
  localparam int ND = 4;
  localparam int VMAX = (1 << (SW - 1)) - 1;
  localparam int VMIN = -VMAX - 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  use_digital = 1'b0;
  logic [ND-1:0]         din = '0;
  logic [1:0]            din_sel = '0;
  logic signed [DW-1:0]  sample = '0;
  logic signed [DW-1:0]  lo_bound = -24'sd100;
  logic signed [DW-1:0]  hi_bound = 24'sd100;
  logic [SW-1:0]         step = 24'd5;
  logic [SW-1:0]         amp_init = 24'd20;
  logic [SW-1:0]         amp_max = 24'd160;
  logic signed [SW-1:0]  sweep_out;
  logic                  hold, locked;

  relock_sweeper #(.DATA_W(DW), .SWEEP_W(SW), .NUM_DIN(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .use_digital(use_digital), .din(din), .din_sel(din_sel),
    .sample(sample), .lo_bound(lo_bound), .hi_bound(hi_bound), .step(step),
    .amp_init(amp_init), .amp_max(amp_max), .sweep_out(sweep_out), .hold(hold),
    .locked(locked)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // behavioural reference: mode 0 locked, 1 searching, 2 returning
  int m_mode = 0, m_out = 0, m_ctr = 0, m_amp = 0;
  bit m_up = 1;

  function automatic int clampv(int v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  always @(posedge clk) begin
    bit ind;
    int top, bot;
    if (!rst_n) begin
      m_mode = 0; m_out = 0; m_ctr = 0; m_amp = 0; m_up = 1;
    end else begin
      if (use_digital) ind = din[din_sel];
      else ind = (int'(sample) >= int'(lo_bound)) && (int'(sample) <= int'(hi_bound));
      if (m_mode != 1 && !ind) begin
        m_mode = 1; m_ctr = m_out; m_amp = int'(amp_init); m_up = 1;
      end else if (m_mode == 1 && ind) begin
        m_mode = 2;
      end else if (m_mode == 1) begin
        top = clampv(m_ctr + m_amp);
        bot = clampv(m_ctr - m_amp);
        if (m_up) begin
          if (m_out + int'(step) >= top) begin m_out = top; m_up = 0; end
          else m_out = m_out + int'(step);
        end else begin
          if (m_out - int'(step) <= bot) begin
            m_out = bot; m_up = 1;
            m_amp = (2 * m_amp > int'(amp_max)) ? int'(amp_max) : 2 * m_amp;
          end else m_out = m_out - int'(step);
        end
      end else if (m_mode == 2) begin
        if (m_out == 0) m_mode = 0;
        else if (m_out > 0) m_out = (m_out - int'(step) < 0) ? 0 : m_out - int'(step);
        else m_out = (m_out + int'(step) > 0) ? 0 : m_out + int'(step);
      end
    end
  end

  task automatic check_val(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check_val(cur_tag, "sweep_out", int'(sweep_out), m_out);
      check_val("R7", "hold", int'(hold), (m_mode == 1) ? 1 : 0);
      check_val("R7", "locked", int'(locked), (m_mode == 1) ? 0 : 1);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mx, mn, start_sign, crossed, centre;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1: reset state
    check_val("R1", "reset out", int'(sweep_out), 0);
    check_val("R1", "reset hold", int'(hold), 0);
    check_val("R1", "reset locked", int'(locked), 1);

    // R8: window edges are inclusive
    cur_tag = "R8";
    sample = 24'sd100; cycles(3);
    check_val("R8", "locked at upper bound", int'(locked), 1);
    sample = -24'sd100; cycles(3);
    check_val("R8", "locked at lower bound", int'(locked), 1);

    // R2: loss
    cur_tag = "R3";
    sample = 24'sd101; cycles(1);
    check_val("R2", "hold after loss", int'(hold), 1);
    check_val("R7", "locked after loss", int'(locked), 0);
    cycles(4);
    check_val("R3", "first upper turning point", int'(sweep_out), 20);

    // R4: next peak after doubling is 40
    cur_tag = "R4";
    mx = -1000;
    for (int i = 0; i < 30; i++) begin
      cycles(1);
      if (int'(sweep_out) > mx) mx = int'(sweep_out);
    end
    check_val("R4", "second peak", mx, 40);

    // R5: swing saturates at amp_max
    cur_tag = "R5";
    mx = -1000; mn = 1000;
    for (int i = 0; i < 1200; i++) begin
      cycles(1);
      if (int'(sweep_out) > mx) mx = int'(sweep_out);
      if (int'(sweep_out) < mn) mn = int'(sweep_out);
    end
    check_val("R5", "max swing", mx, 160);
    check_val("R5", "min swing", mn, -160);

    // R6: return and ramp to zero
    cur_tag = "R6";
    sample = 24'sd0;
    start_sign = (int'(sweep_out) > 0) ? 1 : -1;
    cycles(1);
    check_val("R6", "hold released", int'(hold), 0);
    crossed = 0;
    for (int i = 0; i < 200; i++) begin
      cycles(1);
      if (int'(sweep_out) * start_sign < 0) crossed = 1;
    end
    check_val("R6", "no zero crossing", crossed, 0);
    check_val("R6", "settled at zero", int'(sweep_out), 0);
    check_val("R1", "locked after ramp", int'(locked), 1);

    // R9: loss during ramp recentres on present output
    cur_tag = "R9";
    sample = 24'sd101; cycles(10);
    check_val("R9", "search value before return", int'(sweep_out), -5);
    sample = 24'sd0; cycles(1);
    centre = int'(sweep_out);
    check_val("R9", "ramp entry value", centre, -5);
    sample = 24'sd101; cycles(1);
    check_val("R9", "hold on reloss", int'(hold), 1);
    cycles(4);
    check_val("R9", "peak around new centre", int'(sweep_out), centre + 20);

    // R8: digital line selection, sample ignored
    cur_tag = "R8";
    use_digital = 1'b1; din_sel = 2'd2; din = 4'b0100; sample = 24'sd5000;
    cycles(300);
    check_val("R8", "digital lock out", int'(sweep_out), 0);
    check_val("R8", "digital lock status", int'(locked), 1);
    din = 4'b1011; cycles(1);
    check_val("R8", "selected line low", int'(hold), 1);
    din = 4'b0100; cycles(200);
    check_val("R8", "relocked on line", int'(locked), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule